// File: doc/BRIEF.md
# UART Receive Queue with Fill Threshold and Idle Timeout

This block buffers received bytes for one serial channel. The deserializer hands it a byte with a one-cycle push strobe. The host takes bytes out in arrival order with a one-cycle pop strobe, and each popped byte appears on a registered read port. With queue mode enabled, up to 16 bytes are held. With queue mode disabled, the storage acts as a single holding byte.

Two interrupt requests come out of the block. The data-ready request is raised while the fill level is at or above a threshold. A 2-bit select picks that threshold from a fixed set of four values. The idle-timeout request covers data that sits below the threshold and is never collected. The baud logic supplies one tick per character time. If four such ticks pass with no accepted push and no accepted pop while bytes are waiting below the threshold, the timeout request is raised.

A flush pulse empties the queue and clears both requests. A push that finds no room is discarded and sets a sticky overrun flag.

Top module: `uart_rxq`

## Requirements
- R1: With `fifo_en`=1 the queue accepts 16 bytes. `level` counts them, `full` is high at 16, and bytes leave in the order they entered.
- R2: With `fifo_en`=1, `thr_sel` picks the threshold: 2'b00 selects 1, 2'b01 selects 4, 2'b10 selects 8 and 2'b11 selects 14. `irq_data` is high exactly when `level` is at or above that threshold.
- R3: With `fifo_en`=0 the capacity is one byte. `irq_data` is high whenever that byte is held. A second push before a pop is dropped and sets `overrun`.
- R4: Take a cycle in which bytes are held, `level` is below the threshold and no push or pop is accepted. If four `char_tick` pulses have arrived since the last accepted push or pop, `irq_timeout` is high on the cycle after the fourth pulse.
- R5: Any accepted push or pop clears `irq_timeout` on the next cycle and restarts the tick count.
- R6: `irq_timeout` never rises while the queue is empty, or while `level` is at or above the threshold.
- R7: A `flush` pulse makes `level` 0 and clears `irq_data`, `irq_timeout` and `overrun` on the next cycle. A push or pop in the same cycle is ignored.
- R8: A push to a full queue with no pop in the same cycle is discarded, and the stored bytes are unchanged. It sets `overrun`, which stays high until a flush.
- R9: A pop while empty leaves `pop_data` at its last value and `level` at 0.
- R10: `pop_data` shows the popped byte on the cycle after the pop strobe. After reset, `pop_data`, `level`, `overrun` and both requests are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | 1 | 1 = 16-byte queue mode, 0 = single holding byte |
| thr_sel | input | 2 | Data-ready threshold select |
| flush | input | 1 | One-cycle flush pulse (self-clearing control bit) |
| char_tick | input | 1 | One pulse per character time |
| push | input | 1 | Push strobe from the deserializer |
| push_data | input | 8 | Byte to store |
| pop | input | 1 | Pop strobe from the host |
| pop_data | output | 8 | Last popped byte |
| level | output | 5 | Number of bytes held |
| empty | output | 1 | Level is 0 |
| full | output | 1 | Level has reached the current capacity |
| overrun | output | 1 | Sticky flag: a push was dropped |
| irq_data | output | 1 | Data-ready request |
| irq_timeout | output | 1 | Idle-timeout request |

## Verification
Ordering is checked by filling the queue with a distinct byte pattern and draining it. A lost, repeated or rotated entry shows up as a mismatch. The fill sweep is run under each of the four threshold codes and compares `irq_data` at every level, which separates an off-by-one compare from a wrong code mapping. The timeout tests apply three ticks and then a fourth. They also insert a push or a pop partway through, and they repeat the ticks at the threshold and on an empty queue, which separates a missing restart from a missing threshold or empty gate. Overflow, single-byte mode, flush collisions and empty pops are each driven on their own, so that sticky flags and held values can be told apart from state that was actually changed.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    typedef enum logic [1:0] {
        THR_ONE    = 2'b00,
        THR_FOUR   = 2'b01,
        THR_EIGHT  = 2'b10,
        THR_FOURTEEN = 2'b11
    } thr_sel_e;

    function automatic int unsigned thr_of(input logic [1:0] sel);
        unique case (thr_sel_e'(sel))
            THR_ONE:      return 1;
            THR_FOUR:     return 4;
            THR_EIGHT:    return 8;
            default:      return 14;
        endcase
    endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned DW    = 8,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cap,
    input  logic          flush,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] pop_data,
    output logic [CW-1:0] level,
    output logic          full,
    output logic          push_ok,
    output logic          pop_ok,
    output logic          drop
);

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [AW-1:0]            wr;
        logic [AW-1:0]            rd;
        logic [CW-1:0]            cnt;
        logic [DW-1:0]            dout;
    } st_t;

    st_t st_d, st_q;

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        st_d    = st_q;
        full    = (st_q.cnt >= cap);
        pop_ok  = pop && (st_q.cnt != '0) && !flush;
        push_ok = push && !flush && (!full || pop_ok);
        drop    = push && !flush && !push_ok;
        if (flush) begin
            st_d.wr  = '0;
            st_d.rd  = '0;
            st_d.cnt = '0;
        end else begin
            if (push_ok) begin
                st_d.mem[st_q.wr] = push_data;
                st_d.wr           = nxt(st_q.wr);
            end
            if (pop_ok) begin
                st_d.dout = st_q.mem[st_q.rd];
                st_d.rd   = nxt(st_q.rd);
            end
            st_d.cnt = st_q.cnt + CW'(push_ok) - CW'(pop_ok);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pop_data = st_q.dout;
    assign level    = st_q.cnt;

    // R1
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(DEPTH));

    // R9
    empty_pop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && level == '0 && !push) |=> ($stable(pop_data) && level == '0));

    // R7
    flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (level == '0));

endmodule

// File: rtl/rxq_timer.sv
module rxq_timer #(
    parameter int unsigned TO_CHARS = 4,
    localparam int unsigned TW      = $clog2(TO_CHARS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic activity,
    input  logic nonempty,
    input  logic below,
    input  logic char_tick,
    output logic irq_timeout
);

    typedef struct packed {
        logic [TW-1:0] cnt;
        logic          irq;
    } tm_t;

    tm_t tm_d, tm_q;

    always_comb begin
        tm_d = tm_q;
        if (flush || activity || !nonempty) begin
            tm_d.cnt = '0;
            tm_d.irq = 1'b0;
        end else if (char_tick && tm_q.cnt != TW'(TO_CHARS)) begin
            tm_d.cnt = tm_q.cnt + TW'(1);
            if (tm_q.cnt == TW'(TO_CHARS - 1) && below)
                tm_d.irq = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tm_q <= '0;
        else        tm_q <= tm_d;
    end

    assign irq_timeout = tm_q.irq;

    // R5
    activity_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        activity |=> !irq_timeout);

    // R6
    no_idle_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!nonempty && !activity) |=> !irq_timeout);

endmodule

// File: rtl/uart_rxq.sv
module uart_rxq
    import rxq_pkg::*;
#(
    parameter int unsigned DEPTH    = 16,
    parameter int unsigned DW       = 8,
    parameter int unsigned TO_CHARS = 4,
    localparam int unsigned CW      = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_en,
    input  logic [1:0]    thr_sel,
    input  logic          flush,
    input  logic          char_tick,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] pop_data,
    output logic [CW-1:0] level,
    output logic          empty,
    output logic          full,
    output logic          overrun,
    output logic          irq_data,
    output logic          irq_timeout
);

    logic [CW-1:0] cap, thr;
    logic          push_ok, pop_ok, drop, below;
    logic          ovr_d, ovr_q;

    always_comb begin
        int unsigned t;
        t = thr_of(thr_sel);
        if (t > DEPTH) t = DEPTH;
        cap = fifo_en ? CW'(DEPTH) : CW'(1);
        thr = fifo_en ? CW'(t)     : CW'(1);
    end

    rxq_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap       (cap),
        .flush     (flush),
        .push      (push),
        .push_data (push_data),
        .pop       (pop),
        .pop_data  (pop_data),
        .level     (level),
        .full      (full),
        .push_ok   (push_ok),
        .pop_ok    (pop_ok),
        .drop      (drop)
    );

    assign empty    = (level == '0);
    assign below    = (level < thr);
    assign irq_data = !below;

    rxq_timer #(.TO_CHARS(TO_CHARS)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush       (flush),
        .activity    (push_ok || pop_ok),
        .nonempty    (!empty),
        .below       (below),
        .char_tick   (char_tick),
        .irq_timeout (irq_timeout)
    );

    always_comb begin
        ovr_d = ovr_q;
        if (flush)     ovr_d = 1'b0;
        else if (drop) ovr_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ovr_q <= 1'b0;
        else        ovr_q <= ovr_d;
    end

    assign overrun = ovr_q;

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !flush) |=> (overrun && $stable(level)));

    // R6
    timeout_has_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_timeout |-> !empty);

endmodule

// File: tb/sim_uart_rxq.sv
module sim_uart_rxq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fifo_en = 1'b1;
    logic [1:0] thr_sel = 2'b00;
    logic       flush = 1'b0, char_tick = 1'b0, push = 1'b0, pop = 1'b0;
    logic [7:0] push_data = 8'h00;
    logic [7:0] pop_data;
    logic [4:0] level;
    logic       empty, full, overrun, irq_data, irq_timeout;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    uart_rxq u0 (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .thr_sel(thr_sel),
        .flush(flush), .char_tick(char_tick), .push(push),
        .push_data(push_data), .pop(pop), .pop_data(pop_data),
        .level(level), .empty(empty), .full(full), .overrun(overrun),
        .irq_data(irq_data), .irq_timeout(irq_timeout)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
        push = 1'b0; pop = 1'b0; flush = 1'b0; char_tick = 1'b0;
    endtask

    task automatic do_push(input logic [7:0] b);
        push = 1'b1; push_data = b; cyc();
    endtask

    task automatic do_pop();
        pop = 1'b1; cyc();
    endtask

    task automatic do_flush();
        flush = 1'b1; cyc();
    endtask

    task automatic do_tick();
        char_tick = 1'b1; cyc();
    endtask

    task automatic t_reset();
        chk("R10 reset level", level, 0);
        chk("R10 reset pop_data", pop_data, 0);
        chk("R10 reset irqs", {irq_data, irq_timeout, overrun}, 0);
    endtask

    task automatic t_order();
        fifo_en = 1'b1; thr_sel = 2'b11; do_flush();
        for (int i = 0; i < 16; i++) do_push(8'(8'h30 + i * 7));
        chk("R1 level 16", level, 16);
        chk("R1 full", full, 1);
        for (int i = 0; i < 16; i++) begin
            do_pop();
            chk("R1/R10 order", pop_data, (8'h30 + i * 7) & 8'hFF);
        end
        chk("R1 empty", empty, 1);
    endtask

    task automatic t_thresh();
        int tv[4] = '{1, 4, 8, 14};
        fifo_en = 1'b1;
        for (int s = 0; s < 4; s++) begin
            thr_sel = 2'(s); do_flush();
            chk("R2 empty no irq", irq_data, 0);
            for (int n = 1; n <= 15; n++) begin
                do_push(8'(n));
                chk("R2 threshold", irq_data, (n >= tv[s]) ? 1 : 0);
            end
        end
        do_flush();
    endtask

    task automatic t_single();
        fifo_en = 1'b0; do_flush();
        do_push(8'hA5);
        chk("R3 level 1", level, 1);
        chk("R3 irq_data", irq_data, 1);
        do_push(8'h5A);
        chk("R3 overrun", overrun, 1);
        chk("R3 level stays 1", level, 1);
        do_pop();
        chk("R3 kept first", pop_data, 8'hA5);
        chk("R3 irq low", irq_data, 0);
        fifo_en = 1'b1; do_flush();
    endtask

    task automatic t_timeout();
        fifo_en = 1'b1; thr_sel = 2'b01; do_flush();
        do_push(8'h11); do_push(8'h22);
        for (int i = 0; i < 3; i++) do_tick();
        chk("R4 no irq after 3", irq_timeout, 0);
        do_tick();
        chk("R4 irq after 4", irq_timeout, 1);
        do_push(8'h33);
        chk("R5 push clears", irq_timeout, 0);
        for (int i = 0; i < 2; i++) do_tick();
        do_pop();
        for (int i = 0; i < 3; i++) do_tick();
        chk("R5 pop restarts", irq_timeout, 0);
        do_tick();
        chk("R4 irq again", irq_timeout, 1);
        do_pop();
        chk("R5 pop clears", irq_timeout, 0);
        do_flush();
        for (int i = 0; i < 6; i++) do_tick();
        chk("R6 empty no irq", irq_timeout, 0);
        for (int i = 0; i < 4; i++) do_push(8'(i));
        for (int i = 0; i < 6; i++) do_tick();
        chk("R6 at threshold no irq", irq_timeout, 0);
        do_flush();
    endtask

    task automatic t_overrun();
        fifo_en = 1'b1; thr_sel = 2'b00; do_flush();
        for (int i = 0; i < 16; i++) do_push(8'(8'hC0 + i));
        do_push(8'hEE);
        chk("R8 overrun set", overrun, 1);
        chk("R8 level held", level, 16);
        do_pop();
        chk("R8 head kept", pop_data, 8'hC0);
        for (int i = 1; i < 16; i++) do_pop();
        chk("R8 tail kept", pop_data, 8'hCF);
        chk("R8 overrun sticky", overrun, 1);
        do_flush();
        chk("R7 flush clears overrun", overrun, 0);
    endtask

    task automatic t_flush();
        fifo_en = 1'b1; thr_sel = 2'b00; do_flush();
        do_push(8'h01); do_push(8'h02); do_push(8'h03);
        for (int i = 0; i < 4; i++) do_tick();
        chk("R4 precondition", {irq_data, irq_timeout}, 2'b10);
        flush = 1'b1; push = 1'b1; push_data = 8'h44; cyc();
        chk("R7 level 0", level, 0);
        chk("R7 irqs low", {irq_data, irq_timeout}, 0);
    endtask

    task automatic t_empty_pop();
        fifo_en = 1'b1; do_flush();
        do_push(8'h9C); do_pop();
        chk("R10 popped", pop_data, 8'h9C);
        do_pop();
        chk("R9 pop_data held", pop_data, 8'h9C);
        chk("R9 level 0", level, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        cyc();
        t_order();
        t_thresh();
        t_single();
        t_timeout();
        t_overrun();
        t_flush();
        t_empty_pop();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule